// File: doc/BRIEF.md
# Multi-Speed RGMII Transmit Clock and Data Formatter

This block sits on the MAC side of a reduced-pin gigabit media interface. It runs from a 125 MHz reference clock. On every reference cycle it presents level pairs to an external double-data-rate output cell: one value for the rising half of the cycle and one for the falling half. These pairs cover the transmit clock, the four data lines and the control line. At gigabit rate the clock toggles once per reference cycle and a full byte leaves per cycle, low nibble first. At 100 Mb/s and 10 Mb/s the block builds a 25 MHz or 2.5 MHz clock with exact 50% duty. It does this with half-cycle resolution, taking one nibble per divided period and repeating it on both halves.

The link speed is taken from a select input, but the clock runs only while the MAC confirms that this speed matches the PHY. A speed change or a loss of confirmation never shortens a clock phase. The running period completes, and then the clock parks low with data and control at zero. It starts again from a fresh rising edge only once confirmation is present. A ready strobe marks each cycle in which a new upstream value has just been taken.

Top module: `rgmii_tx_fmt`

## Requirements
- R1: After reset, and whenever parked, `txc_rise`, `txc_fall`, both data nibbles, both control levels and `data_ready` are all 0; the block stays parked while `speed_match` is 0.
- R2: With `speed_sel[1]`=1 (1000 Mb/s), every running cycle has `txc_rise`=1, `txc_fall`=0, `txd_rise`=byte bits 3:0 and `txd_fall`=byte bits 7:4.
- R3: With `speed_sel`=01 (100 Mb/s) the clock period is 5 reference cycles; per cycle the (rise,fall) clock pairs are 11, 11, 10, 00, 00.
- R4: With `speed_sel`=00 (10 Mb/s) the clock period is 50 reference cycles, with both halves high in the first 25 cycles and both low in the last 25.
- R5: At 10 and 100 Mb/s, `txd_rise` and `txd_fall` both carry byte bits 3:0, held for the whole divided period.
- R6: `txctl_rise` equals the captured `tx_en`, and `txctl_fall` equals the captured `tx_en` XOR `tx_err`, paired with the same data.
- R7: `data_ready` is 1 exactly in the cycles where a clock period begins: for one cycle per period at 10/100, and in every running cycle at 1000. The outputs in that cycle show `tx_data`, `tx_en` and `tx_err` as sampled at the clock edge that entered it.
- R8: A change of `speed_sel` or a drop of `speed_match` while running takes effect only after the current period ends; the period completes unchanged and the block then parks for at least one cycle.
- R9: Leaving park needs `speed_match`=1 at a clock edge; the speed is latched from `speed_sel` at that edge, and the first cycle after it begins a period with the clock high.
- R10: Changing `tx_data` in the middle of a 10/100 period has no effect on the outputs until the next period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | Requested speed: 1x = 1000, 01 = 100, 00 = 10 Mb/s |
| speed_match | input | 1 | MAC confirms its speed equals the PHY speed |
| tx_data | input | 8 | Upstream byte (only bits 3:0 used at 10/100) |
| tx_en | input | 1 | Upstream transmit enable |
| tx_err | input | 1 | Upstream transmit error |
| data_ready | output | 1 | A new upstream value was taken at the entering edge |
| txc_rise | output | 1 | Transmit clock level for the first half of the cycle |
| txc_fall | output | 1 | Transmit clock level for the second half of the cycle |
| txd_rise | output | 4 | Data nibble for the first half of the cycle |
| txd_fall | output | 4 | Data nibble for the second half of the cycle |
| txctl_rise | output | 1 | Control level for the first half of the cycle |
| txctl_fall | output | 1 | Control level for the second half of the cycle |

## Verification
Each speed is started from park with bytes whose two nibbles differ, so that nibble duplication at 10/100 can be told apart from the upper nibble appearing at 1000. Each start uses a distinct pairing of enable and error, which separates the XOR on the falling control half from a plain copy. The clock pattern is checked in every cycle of a divided period, so an off-by-one in the divider or the half-cycle split shows up. Mid-period changes of the byte, of the speed select and of the confirmation are applied and checked until the period ends, which tells a deferred switch from a truncated phase.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;

   typedef enum logic [1:0] {
      SPD_10   = 2'b00,
      SPD_100  = 2'b01,
      SPD_1000 = 2'b10
   } spd_e;

   function automatic spd_e spd_decode(input logic [1:0] sel);
      if (sel[1])      return SPD_1000;
      else if (sel[0]) return SPD_100;
      else             return SPD_10;
   endfunction

endpackage

// File: rtl/rgtx_pace.sv
module rgtx_pace
   import rgtx_pkg::*;
#(
   parameter int DIV_100 = 5,
   parameter int DIV_10  = 50,
   parameter int CW      = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    speed_sel,
   input  logic          speed_match,
   output logic          run_q,
   output spd_e          spd_q,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] per_q,
   output logic          load
);

   logic          run_d;
   spd_e          spd_d;
   logic [CW-1:0] cnt_d;
   logic          last;

   always_comb begin
      unique case (spd_q)
         SPD_1000: per_q = CW'(1);
         SPD_100:  per_q = CW'(DIV_100);
         default:  per_q = CW'(DIV_10);
      endcase
   end

   assign last = (cnt_q == CW'(per_q - 1'b1));

   always_comb begin
      run_d = run_q;
      spd_d = spd_q;
      cnt_d = cnt_q;
      if (!run_q) begin
         if (speed_match) begin
            run_d = 1'b1;
            spd_d = spd_decode(speed_sel);
            cnt_d = '0;
         end
      end else if (last) begin
         cnt_d = '0;
         if (!(speed_match && (spd_decode(speed_sel) == spd_q)))
            run_d = 1'b0;
      end else begin
         cnt_d = CW'(cnt_q + 1'b1);
      end
   end

   assign load = run_d && (cnt_d == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         spd_q <= SPD_10;
         cnt_q <= '0;
      end else begin
         run_q <= run_d;
         spd_q <= spd_d;
         cnt_q <= cnt_d;
      end
   end

   // R8: a period that has not reached its last cycle always goes on
   a_r8_full_period: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !last) |=> (run_q && $stable(spd_q)));

   // R9: starting needs confirmation at the edge
   a_r9_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(speed_match));

   // R9: a start always lands on phase zero
   a_r9_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> (cnt_q == '0));

endmodule

// File: rtl/rgtx_clkgen.sv
module rgtx_clkgen #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] per,
   output logic          txc_rise,
   output logic          txc_fall
);

   logic [CW:0] slot_r;
   logic [CW:0] slot_f;
   logic [CW:0] per_x;

   assign slot_r = {cnt, 1'b0};
   assign slot_f = {cnt, 1'b1};
   assign per_x  = {1'b0, per};

   assign txc_rise = run && (slot_r < per_x);
   assign txc_fall = run && (slot_f < per_x);

   // R3: a high second half never follows a low first half (no runt pulse)
   a_r3_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
      txc_fall |-> txc_rise);

   // R9: every run begins with the clock high
   a_r9_first_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> txc_rise);

endmodule

// File: rtl/rgtx_lane.sv
module rgtx_lane #(
   parameter int NIB = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic             fast,
   input  logic [2*NIB-1:0] tx_data,
   input  logic             tx_en,
   input  logic             tx_err,
   output logic [NIB-1:0]   txd_rise,
   output logic [NIB-1:0]   txd_fall,
   output logic             txctl_rise,
   output logic             txctl_fall
);

   logic [2*NIB-1:0] dat_q;
   logic             en_q;
   logic             err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_q <= '0;
         en_q  <= 1'b0;
         err_q <= 1'b0;
      end else if (load) begin
         dat_q <= tx_data;
         en_q  <= tx_en;
         err_q <= tx_err;
      end
   end

   assign txd_rise   = run ? dat_q[NIB-1:0] : '0;
   assign txd_fall   = !run ? '0 : (fast ? dat_q[2*NIB-1:NIB] : dat_q[NIB-1:0]);
   assign txctl_rise = run && en_q;
   assign txctl_fall = run && (en_q ^ err_q);

   // R10: without a capture, a running lane holds its levels
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(load)) |->
         ($stable(txd_rise) && $stable(txd_fall) && $stable(txctl_rise)));

endmodule

// File: rtl/rgmii_tx_fmt.sv
module rgmii_tx_fmt
   import rgtx_pkg::*;
#(
   parameter int REF_MHZ = 125,
   parameter int NIB     = 4
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic [1:0]       speed_sel,
   input  logic             speed_match,
   input  logic [2*NIB-1:0] tx_data,
   input  logic             tx_en,
   input  logic             tx_err,
   output logic             data_ready,
   output logic             txc_rise,
   output logic             txc_fall,
   output logic [NIB-1:0]   txd_rise,
   output logic [NIB-1:0]   txd_fall,
   output logic             txctl_rise,
   output logic             txctl_fall
);

   localparam int DIV_100 = REF_MHZ / 25;
   localparam int DIV_10  = (REF_MHZ * 2) / 5;
   localparam int CW      = $clog2(DIV_10 + 1);

   generate
      if (REF_MHZ % 25 != 0) begin : g_bad_ref
         $error("REF_MHZ must be a multiple of 25");
      end
      if (DIV_100 < 2) begin : g_bad_div
         $error("REF_MHZ too low for the 100 Mb/s clock");
      end
      if (NIB < 1) begin : g_bad_nib
         $error("NIB must be at least 1");
      end
   endgenerate

   logic          run_q;
   spd_e          spd_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] per_q;
   logic          load;

   rgtx_pace #(.DIV_100(DIV_100), .DIV_10(DIV_10), .CW(CW)) u_pace (
      .clk         (clk_ref),
      .rst_n       (rst_n),
      .speed_sel   (speed_sel),
      .speed_match (speed_match),
      .run_q       (run_q),
      .spd_q       (spd_q),
      .cnt_q       (cnt_q),
      .per_q       (per_q),
      .load        (load)
   );

   rgtx_clkgen #(.CW(CW)) u_clk (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .run      (run_q),
      .cnt      (cnt_q),
      .per      (per_q),
      .txc_rise (txc_rise),
      .txc_fall (txc_fall)
   );

   rgtx_lane #(.NIB(NIB)) u_lane (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .load       (load),
      .run        (run_q),
      .fast       (spd_q == SPD_1000),
      .tx_data    (tx_data),
      .tx_en      (tx_en),
      .tx_err     (tx_err),
      .txd_rise   (txd_rise),
      .txd_fall   (txd_fall),
      .txctl_rise (txctl_rise),
      .txctl_fall (txctl_fall)
   );

   assign data_ready = run_q && (cnt_q == '0);

   // R7: at divided speeds the strobe lasts a single cycle per period
   a_r7_single_ready: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (data_ready && (spd_q != SPD_1000)) |=> !data_ready);

   // R7: the strobe coincides with a clock rising edge
   a_r7_ready_on_rise: assert property (@(posedge clk_ref) disable iff (!rst_n)
      data_ready |-> txc_rise);

   // R1: a parked clock produces no data or control
   a_r1_parked_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !txc_rise |-> (!data_ready && (spd_q == SPD_1000 || !txctl_rise || run_q)));

endmodule

// File: tb/tb_rgmii_tx_fmt.sv
module tb_rgmii_tx_fmt;

   localparam time CYC = 20ns;

   logic       clk_ref = 1'b0;
   logic       rst_n;
   logic [1:0] speed_sel;
   logic       speed_match;
   logic [7:0] tx_data;
   logic       tx_en;
   logic       tx_err;
   logic       data_ready, txc_rise, txc_fall, txctl_rise, txctl_fall;
   logic [3:0] txd_rise, txd_fall;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CYC/2) clk_ref = ~clk_ref;

   rgmii_tx_fmt dut (
      .clk_ref(clk_ref), .rst_n(rst_n), .speed_sel(speed_sel),
      .speed_match(speed_match), .tx_data(tx_data), .tx_en(tx_en),
      .tx_err(tx_err), .data_ready(data_ready), .txc_rise(txc_rise),
      .txc_fall(txc_fall), .txd_rise(txd_rise), .txd_fall(txd_fall),
      .txctl_rise(txctl_rise), .txctl_fall(txctl_fall)
   );

   // packed view: {clk rise, clk fall, data rise, data fall, ctl rise, ctl fall, ready}
   function automatic logic [12:0] obs();
      return {txc_rise, txc_fall, txd_rise, txd_fall, txctl_rise, txctl_fall, data_ready};
   endfunction

   function automatic int period_of(logic [1:0] s);
      if (s[1]) return 1;
      if (s[0]) return 5;
      return 50;
   endfunction

   function automatic logic [12:0] expect_at(logic [1:0] s, int c, logic [7:0] d,
                                             logic en, logic er);
      int p;
      p = period_of(s);
      return {(2*c < p), (2*c+1 < p), d[3:0], (p == 1) ? d[7:4] : d[3:0],
              en, en ^ er, (c == 0)};
   endfunction

   task automatic check(string req, logic [12:0] act, logic [12:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic park_all();
      @(negedge clk_ref);
      speed_match = 1'b0;
      repeat (60) @(negedge clk_ref);
      check("R1 R8 parked", obs(), 13'b0);
   endtask

   // start a speed from park and check one full divided period
   task automatic run_period(string req, logic [1:0] s, logic [7:0] d, logic en, logic er);
      speed_sel = s; tx_data = d; tx_en = en; tx_err = er;
      speed_match = 1'b1;
      for (int c = 0; c < period_of(s); c++) begin
         @(negedge clk_ref);
         check(req, obs(), expect_at(s, c, d, en, er));
      end
   endtask

   typedef struct packed {
      logic [1:0] sel;
      logic [7:0] dat;
      logic       en;
      logic       er;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{2'b10, 8'hA5, 1'b1, 1'b0},
      '{2'b01, 8'h3C, 1'b1, 1'b1},
      '{2'b00, 8'h96, 1'b0, 1'b1},
      '{2'b11, 8'h1E, 1'b0, 1'b0},
      '{2'b01, 8'hF0, 1'b0, 1'b0},
      '{2'b00, 8'h0F, 1'b1, 1'b0}
   };

   initial begin
      #(CYC * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; speed_sel = 2'b00; speed_match = 1'b0;
      tx_data = 8'h00; tx_en = 1'b0; tx_err = 1'b0;
      repeat (3) @(negedge clk_ref);
      check("R1 in reset", obs(), 13'b0);
      rst_n = 1'b1;
      tx_data = 8'hFF; tx_en = 1'b1;
      repeat (5) @(negedge clk_ref);
      check("R1 no match keeps park", obs(), 13'b0);

      // table walk: every speed from park, distinct nibbles and control pairs
      for (int i = 0; i < NV; i++) begin
         park_all();
         run_period("R2 R3 R4 R5 R6 R7 R9 table", VECS[i].sel, VECS[i].dat,
                    VECS[i].en, VECS[i].er);
      end

      // R10: mid-period byte change at 10 Mb/s is ignored until the next period
      park_all();
      speed_sel = 2'b00; tx_data = 8'h5A; tx_en = 1'b1; tx_err = 1'b0;
      speed_match = 1'b1;
      for (int c = 0; c < 50; c++) begin
         @(negedge clk_ref);
         check("R10 R4 hold", obs(), expect_at(2'b00, c, 8'h5A, 1'b1, 1'b0));
         if (c == 3) begin tx_data = 8'hC3; tx_en = 1'b0; tx_err = 1'b1; end
      end
      @(negedge clk_ref);
      check("R10 R7 next period", obs(), expect_at(2'b00, 0, 8'hC3, 1'b0, 1'b1));

      // R8: speed change mid-period at 10 Mb/s waits for period end
      for (int c = 1; c < 50; c++) begin
         @(negedge clk_ref);
         check("R8 period completes", obs(), expect_at(2'b00, c, 8'hC3, 1'b0, 1'b1));
         if (c == 5) begin speed_sel = 2'b10; tx_data = 8'h7E; tx_en = 1'b1; tx_err = 1'b1; end
      end
      @(negedge clk_ref);
      check("R8 one parked cycle", obs(), 13'b0);
      @(negedge clk_ref);
      check("R9 R2 restart at 1000", obs(), expect_at(2'b10, 0, 8'h7E, 1'b1, 1'b1));

      // R2: byte stream at 1000, a new value every cycle
      for (int k = 0; k < 4; k++) begin
         tx_data = 8'h12 + 8'(k * 8'h31); tx_en = k[0]; tx_err = k[1];
         @(negedge clk_ref);
         check("R2 R6 R7 stream", obs(), expect_at(2'b10, 0, 8'h12 + 8'(k * 8'h31), k[0], k[1]));
      end

      // R8: confirmation drop in mid 100 Mb/s period
      park_all();
      speed_sel = 2'b01; tx_data = 8'hB4; tx_en = 1'b1; tx_err = 1'b0;
      speed_match = 1'b1;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk_ref);
         check("R8 R3 drop completes", obs(), expect_at(2'b01, c, 8'hB4, 1'b1, 1'b0));
         if (c == 1) speed_match = 1'b0;
      end
      for (int k = 0; k < 3; k++) begin
         @(negedge clk_ref);
         check("R8 R1 stays parked", obs(), 13'b0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule